// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block carries out one multi-register load or store for a 32-bit core with sixteen general registers. On a start pulse it captures the low 25 bits of the instruction word, the current base register value and the processor mode. It then walks the 16-bit register list and makes one word access on a request/acknowledge memory port for every set bit. A load writes each returned word into the register file, and a store sends the register file's read data out as write data. The block always sweeps the list in the direction the address moves, so the lowest-numbered register ends up at the lowest address.

The state machine has three states. ST_IDLE waits for work. ST_XFER holds one memory request until it is acknowledged. ST_FINISH lasts exactly one cycle and pulses done. The transitions are as follows. The accept transition goes from ST_IDLE to ST_XFER when start arrives and the list is non-empty. The empty transition goes from ST_IDLE straight to ST_FINISH when the list is empty. The step transition keeps the machine in ST_XFER on an acknowledge that leaves bits outstanding. The last transition goes from ST_XFER to ST_FINISH on the acknowledge of the final register. The return transition goes from ST_FINISH back to ST_IDLE.

Two side effects come out with done. One is the final stepped address, which serves as the writeback value for the base register. The other is a strobe that tells the core to copy its saved status into the current status. When the user-bank view is active, the register-file ports carry a bank flag for each register, which selects the user copy of a banked register in place of the active one.

Top module: `lsm_seq_top`

## Requirements
- R1: `start` is accepted only in ST_IDLE. While `busy` is high, `start` and new instruction fields have no effect on the running sequence, and `busy` falls in the cycle after `done`.
- R2: Exactly one memory access is made for each set bit of the register list (`instr_lo[15:0]`), and no access is made for clear bits.
- R3: Each access address follows the stepping flags. `instr_lo[24]` set means step before use, and `instr_lo[23]` set means up. The pointer starts at the base value and moves by 4 after each access, so consecutive addresses differ by exactly 4.
- R4: Registers are taken in ascending order when stepping up and in descending order when stepping down. The lowest-numbered register therefore always lands at the lowest address.
- R5: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` stay stable. The sequencer moves to the next register only on `mem_ack`.
- R6: A load (`instr_lo[20]`=1) writes `mem_rdata` into the current register in the acknowledge cycle, through `rf_wr_*`. A store (`instr_lo[20]`=0) drives `mem_wdata` from `rf_rd_data` and sets `mem_we`.
- R7: When `instr_lo[21]` is set, `wb_en` pulses with `done`, `wb_idx` equals `instr_lo[19:16]`, and `wb_data` equals the final stepped pointer. When the bit is clear, `wb_en` stays low.
- R8: The user-bank view is active when `instr_lo[22]` is set on a store, or on a load whose list lacks register 15. In this view the bank flag is high for registers 13 and 14 in any exception mode. In fast-interrupt mode it is also high for registers 8 through 12. Mode codes: 0 user, 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined, 6 system. Modes 1 to 5 are exception modes.
- R9: A load with `instr_lo[22]` set and register 15 in the list uses the active bank, so all bank flags are low, and pulses `psr_restore` together with `done`. In every other case `psr_restore` stays low.
- R10: An empty register list gives `done` in the cycle after acceptance, with no memory access, and the writeback value equals the unchanged base.
- R11: `done` is high for exactly one cycle per accepted instruction, and no memory request is active while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| instr_lo | input | 25 | Low instruction bits: list, base index, load, writeback, S, up, pre |
| base_val | input | 32 | Current base register value |
| cpu_mode | input | 3 | Processor mode code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| rf_rd_idx | output | 4 | Register file read index |
| rf_rd_user | output | 1 | Read selects the user-bank copy |
| rf_rd_data | input | 32 | Register file read data |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_idx | output | 4 | Register file write index |
| rf_wr_user | output | 1 | Write selects the user-bank copy |
| rf_wr_data | output | 32 | Register file write data |
| wb_en | output | 1 | Base writeback enable |
| wb_idx | output | 4 | Base register index |
| wb_data | output | 32 | Final base value |
| psr_restore | output | 1 | Copy saved status to current status |

## Verification
The bench builds the block with its default sixteen registers and 32-bit words. At this size the full stepping and direction space can be swept. That space is all sixteen combinations of pre, up, S and load, each with writeback on and off. Each combination runs against a set of register lists: empty, lone low and lone high registers, the full list, and patterns that fall inside or across the banked ranges. Each of these runs in user, fast-interrupt, interrupt and system modes. Acknowledge delays vary per access, and stray start pulses arrive mid-sequence. Expected addresses, orders, bank flags and writeback values are recomputed by stepping a pointer in the bench.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_FINISH = 2'd2
    } lsm_state_e;

    localparam logic [2:0] MODE_USER = 3'd0;
    localparam logic [2:0] MODE_FIQ  = 3'd1;
    localparam logic [2:0] MODE_IRQ  = 3'd2;
    localparam logic [2:0] MODE_SVC  = 3'd3;
    localparam logic [2:0] MODE_ABT  = 3'd4;
    localparam logic [2:0] MODE_UND  = 3'd5;
    localparam logic [2:0] MODE_SYS  = 3'd6;

    typedef struct packed {
        logic       pre;
        logic       up;
        logic       sbit;
        logic       wback;
        logic       load;
        logic [3:0] base_idx;
    } lsm_ctrl_t;

    function automatic logic mode_is_exc(input logic [2:0] m);
        return (m >= MODE_FIQ) && (m <= MODE_UND);
    endfunction

endpackage

// File: rtl/lsm_order.sv
module lsm_order #(
    parameter int REG_CNT = 16,
    localparam int IDX_W = $clog2(REG_CNT)
) (
    input  logic [REG_CNT-1:0] mask,
    input  logic               ascend,
    output logic [IDX_W-1:0]   idx
);
    logic [IDX_W-1:0] lo_idx;
    logic [IDX_W-1:0] hi_idx;

    // lowest set bit: scan downward so the last hit is the smallest
    always_comb begin
        lo_idx = '0;
        for (int i = REG_CNT - 1; i >= 0; i--) begin
            if (mask[i]) lo_idx = IDX_W'(i);
        end
    end

    // highest set bit: scan upward so the last hit is the largest
    always_comb begin
        hi_idx = '0;
        for (int i = 0; i < REG_CNT; i++) begin
            if (mask[i]) hi_idx = IDX_W'(i);
        end
    end

    assign idx = ascend ? lo_idx : hi_idx;

endmodule

// File: rtl/lsm_addr.sv
module lsm_addr #(
    parameter int DATA_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [DATA_W-1:0] ptr,
    input  logic              pre,
    input  logic              up,
    output logic [DATA_W-1:0] addr_use,
    output logic [DATA_W-1:0] ptr_next
);
    localparam logic [DATA_W-1:0] STEP = DATA_W'(WORD_BYTES);

    always_comb begin
        ptr_next = up ? (ptr + STEP) : (ptr - STEP);
        addr_use = pre ? ptr_next : ptr;
    end

endmodule

// File: rtl/lsm_bank_map.sv
module lsm_bank_map #(
    parameter int REG_CNT   = 16,
    parameter int FIQ_LO    = 8,
    parameter int FIQ_HI    = 12,
    parameter int SHADOW_LO = 13,
    parameter int SHADOW_HI = 14,
    localparam int IDX_W = $clog2(REG_CNT)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [2:0]       mode,
    input  logic             user_view,
    output logic             user_sel
);
    import lsm_pkg::*;

    localparam logic [IDX_W-1:0] F_LO = IDX_W'(FIQ_LO);
    localparam logic [IDX_W-1:0] F_HI = IDX_W'(FIQ_HI);
    localparam logic [IDX_W-1:0] S_LO = IDX_W'(SHADOW_LO);
    localparam logic [IDX_W-1:0] S_HI = IDX_W'(SHADOW_HI);

    logic in_shadow;
    logic in_fiq;

    always_comb begin
        in_shadow = (idx >= S_LO) && (idx <= S_HI);
        in_fiq    = (idx >= F_LO) && (idx <= F_HI);
        user_sel  = user_view &&
                    ((mode_is_exc(mode) && in_shadow) ||
                     ((mode == MODE_FIQ) && in_fiq));
    end

endmodule

// File: rtl/lsm_seq_top.sv
module lsm_seq_top #(
    parameter int DATA_W     = 32,
    parameter int REG_CNT    = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(REG_CNT),
    localparam int INSTR_W   = REG_CNT + IDX_W + 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr_lo,
    input  logic [DATA_W-1:0]  base_val,
    input  logic [2:0]         cpu_mode,
    output logic               busy,
    output logic               done,
    output logic               mem_req,
    output logic               mem_we,
    output logic [DATA_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [IDX_W-1:0]   rf_rd_idx,
    output logic               rf_rd_user,
    input  logic [DATA_W-1:0]  rf_rd_data,
    output logic               rf_wr_en,
    output logic [IDX_W-1:0]   rf_wr_idx,
    output logic               rf_wr_user,
    output logic [DATA_W-1:0]  rf_wr_data,
    output logic               wb_en,
    output logic [IDX_W-1:0]   wb_idx,
    output logic [DATA_W-1:0]  wb_data,
    output logic               psr_restore
);
    import lsm_pkg::*;

    // instruction field positions
    localparam int POS_BASE = REG_CNT;
    localparam int POS_LOAD = REG_CNT + IDX_W;
    localparam int POS_WB   = POS_LOAD + 1;
    localparam int POS_S    = POS_LOAD + 2;
    localparam int POS_UP   = POS_LOAD + 3;
    localparam int POS_PRE  = POS_LOAD + 4;
    localparam int PC_IDX   = REG_CNT - 1;

    lsm_state_e         state_q, state_d;
    lsm_ctrl_t          ctrl_q;
    logic [REG_CNT-1:0] remain_q, remain_nxt;
    logic [DATA_W-1:0]  ptr_q;
    logic [2:0]         mode_q;
    logic               restore_q;
    logic               user_view_q;

    logic [IDX_W-1:0]   cur_idx;
    logic [DATA_W-1:0]  addr_use;
    logic [DATA_W-1:0]  ptr_next;
    logic               cur_user;
    logic               accept;
    logic               list_empty;
    logic               last_ack;

    lsm_order #(.REG_CNT(REG_CNT)) u_order (
        .mask   (remain_q),
        .ascend (ctrl_q.up),
        .idx    (cur_idx)
    );

    lsm_addr #(.DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)) u_addr (
        .ptr      (ptr_q),
        .pre      (ctrl_q.pre),
        .up       (ctrl_q.up),
        .addr_use (addr_use),
        .ptr_next (ptr_next)
    );

    lsm_bank_map #(.REG_CNT(REG_CNT)) u_bank (
        .idx       (cur_idx),
        .mode      (mode_q),
        .user_view (user_view_q),
        .user_sel  (cur_user)
    );

    always_comb begin
        remain_nxt          = remain_q;
        remain_nxt[cur_idx] = 1'b0;
    end

    assign accept     = start && (state_q == ST_IDLE);
    assign list_empty = (instr_lo[REG_CNT-1:0] == '0);
    assign last_ack   = mem_ack && (remain_nxt == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = list_empty ? ST_FINISH : ST_XFER;
            end
            ST_XFER: begin
                if (last_ack) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and captured context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            ctrl_q      <= '0;
            remain_q    <= '0;
            ptr_q       <= '0;
            mode_q      <= MODE_USER;
            restore_q   <= 1'b0;
            user_view_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                ctrl_q.pre      <= instr_lo[POS_PRE];
                ctrl_q.up       <= instr_lo[POS_UP];
                ctrl_q.sbit     <= instr_lo[POS_S];
                ctrl_q.wback    <= instr_lo[POS_WB];
                ctrl_q.load     <= instr_lo[POS_LOAD];
                ctrl_q.base_idx <= instr_lo[POS_BASE +: IDX_W];
                remain_q        <= instr_lo[REG_CNT-1:0];
                ptr_q           <= base_val;
                mode_q          <= cpu_mode;
                restore_q       <= instr_lo[POS_S] && instr_lo[POS_LOAD] &&
                                   instr_lo[PC_IDX];
                user_view_q     <= instr_lo[POS_S] &&
                                   !(instr_lo[POS_LOAD] && instr_lo[PC_IDX]);
            end else if ((state_q == ST_XFER) && mem_ack) begin
                remain_q <= remain_nxt;
                ptr_q    <= ptr_next;
            end
        end
    end

    // outputs
    always_comb begin
        busy        = 1'b0;
        done        = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        rf_rd_idx   = '0;
        rf_rd_user  = 1'b0;
        rf_wr_en    = 1'b0;
        rf_wr_idx   = '0;
        rf_wr_user  = 1'b0;
        rf_wr_data  = '0;
        wb_en       = 1'b0;
        wb_idx      = '0;
        wb_data     = '0;
        psr_restore = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_XFER: begin
                busy       = 1'b1;
                mem_req    = 1'b1;
                mem_we     = !ctrl_q.load;
                mem_addr   = addr_use;
                rf_rd_idx  = cur_idx;
                rf_rd_user = cur_user;
                mem_wdata  = ctrl_q.load ? '0 : rf_rd_data;
                rf_wr_en   = ctrl_q.load && mem_ack;
                rf_wr_idx  = cur_idx;
                rf_wr_user = cur_user;
                rf_wr_data = mem_rdata;
            end
            ST_FINISH: begin
                busy        = 1'b1;
                done        = 1'b1;
                wb_en       = ctrl_q.wback;
                wb_idx      = ctrl_q.base_idx;
                wb_data     = ptr_q;
                psr_restore = restore_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              rf_wr_en,
    input logic              wb_en,
    input logic              psr_restore
);
    localparam logic [DATA_W-1:0] STEP = DATA_W'(4);

    // R5
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    no_req_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R1
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R6
    load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (mem_req && mem_ack && !mem_we));

    // R9
    restore_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psr_restore |-> done);

    // R7
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req && mem_ack)) |->
        ((mem_addr == $past(mem_addr) + STEP) || (mem_addr == $past(mem_addr) - STEP)));

endmodule

bind lsm_seq_top lsm_seq_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .rf_wr_en    (rf_wr_en),
    .wb_en       (wb_en),
    .psr_restore (psr_restore)
);

// File: tb/lsm_seq_top_tb.sv
`timescale 1ns/1ps
module lsm_seq_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [24:0] instr_lo = '0;
    logic [31:0] base_val = '0;
    logic [2:0]  cpu_mode = '0;
    logic        busy, done, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  rf_rd_idx;
    logic        rf_rd_user;
    logic [31:0] rf_rd_data;
    logic        rf_wr_en;
    logic [3:0]  rf_wr_idx;
    logic        rf_wr_user;
    logic [31:0] rf_wr_data;
    logic        wb_en;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data;
    logic        psr_restore;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    // register file model: value encodes bank flag and index
    assign rf_rd_data = 32'h5A00_0000 | {23'd0, rf_rd_user, 4'd0, rf_rd_idx};

    lsm_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr_lo(instr_lo),
        .base_val(base_val), .cpu_mode(cpu_mode), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rf_rd_idx(rf_rd_idx), .rf_rd_user(rf_rd_user), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_user(rf_wr_user),
        .rf_wr_data(rf_wr_data), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_data(wb_data), .psr_restore(psr_restore)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic pre, input logic up, input logic sb,
                           input logic wb, input logic ld, input logic [15:0] lst,
                           input logic [2:0] md, input logic [3:0] bidx,
                           input logic [31:0] bval, input bit noisy);
        logic [31:0] ptr;
        logic [31:0] ea [16];
        logic [3:0]  ei [16];
        int          n;
        logic        restore, uview, exc, fiq, usel;
        ptr = bval;
        n = 0;
        for (int k = 0; k < 16; k++) begin
            int r;
            r = up ? k : 15 - k;
            if (lst[r]) begin
                ea[n] = pre ? (up ? ptr + 4 : ptr - 4) : ptr;
                ptr   = up ? ptr + 4 : ptr - 4;
                ei[n] = 4'(r);
                n++;
            end
        end
        restore = sb && ld && lst[15];
        uview   = sb && !restore;
        exc     = (md >= 3'd1) && (md <= 3'd5);
        fiq     = (md == 3'd1);

        @(negedge clk);
        start    = 1'b1;
        instr_lo = {pre, up, sb, wb, ld, bidx, lst};
        cpu_mode = md;
        base_val = bval;
        @(negedge clk);
        start = 1'b0;

        for (int j = 0; j < n; j++) begin
            int d;
            usel = uview && ((exc && (ei[j] == 4'd13 || ei[j] == 4'd14)) ||
                             (fiq && ei[j] >= 4'd8 && ei[j] <= 4'd12));
            chk("R2 request present", {31'd0, mem_req}, 32'd1);
            chk("R1 busy during transfer", {31'd0, busy}, 32'd1);
            chk("R3 address", mem_addr, ea[j]);
            chk("R6 direction", {31'd0, mem_we}, {31'd0, !ld});
            if (!ld) begin
                chk("R4 store order", {28'd0, rf_rd_idx}, {28'd0, ei[j]});
                chk("R8 store bank/data", mem_wdata,
                    32'h5A00_0000 | {23'd0, usel, 4'd0, ei[j]});
            end
            d = (j + n) % 3;
            for (int c = 0; c < d; c++) begin
                if (noisy) begin
                    start    = 1'b1;
                    instr_lo = {~pre, ~up, 1'b0, 1'b0, ~ld, ~bidx, ~lst};
                    base_val = bval ^ 32'hFFFF_0000;
                end
                @(negedge clk);
                start = 1'b0;
                chk("R5 request held", {31'd0, mem_req}, 32'd1);
                chk("R5 address held", mem_addr, ea[j]);
                chk("R5 direction held", {31'd0, mem_we}, {31'd0, !ld});
                if (!ld) chk("R5 data held", mem_wdata,
                             32'h5A00_0000 | {23'd0, usel, 4'd0, ei[j]});
            end
            mem_ack   = 1'b1;
            mem_rdata = ea[j] ^ 32'h3C3C_0000;
            #1;
            chk("R6 rf write enable", {31'd0, rf_wr_en}, {31'd0, ld});
            if (ld) begin
                chk("R4 load order", {28'd0, rf_wr_idx}, {28'd0, ei[j]});
                chk("R8 load bank", {31'd0, rf_wr_user}, {31'd0, usel});
                chk("R6 load data", rf_wr_data, ea[j] ^ 32'h3C3C_0000);
            end
            @(negedge clk);
            mem_ack = 1'b0;
        end

        chk("R11 done pulse", {31'd0, done}, 32'd1);
        chk("R11 no request at done", {31'd0, mem_req}, 32'd0);
        chk("R7 writeback enable", {31'd0, wb_en}, {31'd0, wb});
        if (wb) begin
            chk("R7 writeback index", {28'd0, wb_idx}, {28'd0, bidx});
            chk("R7 writeback value", wb_data, ptr);
        end
        if (n == 0) chk("R10 empty list base unchanged", ptr, bval);
        chk("R9 status restore", {31'd0, psr_restore}, {31'd0, restore});
        @(negedge clk);
        chk("R11 done falls", {31'd0, done}, 32'd0);
        chk("R1 idle after done", {31'd0, busy}, 32'd0);
        chk("R2 no stray request", {31'd0, mem_req}, 32'd0);
    endtask

    initial begin
        logic [15:0] lists [7];
        logic [2:0]  modes [4];
        int          run;
        lists[0] = 16'h0000; lists[1] = 16'h0001; lists[2] = 16'h8000;
        lists[3] = 16'hA5A5; lists[4] = 16'hFFFF; lists[5] = 16'h6100;
        lists[6] = 16'h7F00;
        modes[0] = 3'd0; modes[1] = 3'd1; modes[2] = 3'd2; modes[3] = 3'd6;

        repeat (3) @(negedge clk);
        chk("R11 reset done", {31'd0, done}, 32'd0);
        chk("R1 reset busy", {31'd0, busy}, 32'd0);
        chk("R2 reset request", {31'd0, mem_req}, 32'd0);
        chk("R7 reset writeback", {31'd0, wb_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run = 0;
        for (int f = 0; f < 32; f++) begin
            for (int li = 0; li < 7; li++) begin
                for (int mi = 0; mi < 4; mi++) begin
                    run_one(f[4], f[3], f[2], f[1], f[0], lists[li], modes[mi],
                            4'(run), 32'h0001_0000 + 32'(run * 64), (run % 2) == 1);
                    run++;
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule